// File: doc/BRIEF.md
# Scannable Register Chain

This block is a row of WIDTH storage bits. Each bit behaves as an ordinary clock-enabled flip-flop in functional mode. When test mode is selected, the bits are joined into a serial shift path. Every cell has its own data input and its own capture enable. The mode select, the serial input and an active-low clear are shared by all cells. The parallel true and complement outputs are exposed, and the last cell drives the serial output.

A test runs in three steps. First, a pattern is shifted in with the mode select high for WIDTH clocks. Next, the mode select is lowered for one clock so that every enabled cell captures its data input. Finally, the mode select is raised again and the captured word is shifted out, most significant cell first.

Test mode takes priority over everything else. While shifting, the capture enables and data inputs have no effect, and the clear is suppressed as well. A clear therefore acts only in functional mode, and raising the mode select during a clear releases it.

Top module: `scan_reg_chain`

## Requirements
- R1: With scan_en=0 and clr_n=1, on a rising clk edge every cell i whose cap_en[i]=1 loads d[i] into q[i].
- R2: With scan_en=0 and clr_n=1, a cell whose cap_en[i]=0 keeps its q[i] over the clock edge, whatever d[i] is.
- R3: With scan_en=1, on a rising clk edge q[0] takes scan_in and q[i] takes the old q[i-1] for i>0, regardless of cap_en and d.
- R4: With scan_en=0 and clr_n=0, all q bits go to 0 at once, without waiting for a clock edge, and stay 0 while that condition holds.
- R5: With scan_en=1, clr_n=0 has no effect, and the chain keeps shifting as in R3.
- R6: qb is always the bitwise complement of q.
- R7: scan_out always equals q[WIDTH-1].
- R8: After WIDTH shift clocks, the bit shifted in first sits in q[WIDTH-1] and the last one in q[0]. A word captured in one functional clock leaves on scan_out over WIDTH shift clocks, starting with q[WIDTH-1].
- R9: Raising scan_en while clr_n is still 0 releases the clear, so the next edge shifts scan_in into q[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low asynchronous clear, effective only when scan_en=0 |
| scan_en | input | 1 | 1 = serial shift mode, 0 = functional mode |
| scan_in | input | 1 | Serial input into cell 0 |
| cap_en | input | WIDTH | Per-cell capture enable in functional mode |
| d | input | WIDTH | Per-cell functional data |
| q | output | WIDTH | Stored bits |
| qb | output | WIDTH | Complement of q |
| scan_out | output | 1 | Serial output, equal to the last cell |

## Verification
The assertions check the following on every cycle:
- the per-edge rules of the three modes: capture of enabled bits, holding of disabled bits, and the one-place shift;
- that q stays zero while a functional-mode clear is held;
- the complement relation between q and qb;
- that the serial output follows the last cell.

Some behaviour only the bench scenarios can show:
- that the clear acts between clock edges;
- that clr_n low during shifting is ignored;
- that raising scan_en mid-clear releases the chain;
- that a whole word travels through a load, capture and unload sequence with its bit order intact.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_SHIFT   = 2'd2
  } cell_mode_t;

  // Priority: shift wins over capture/hold
  function automatic cell_mode_t pick_mode(input logic shift, input logic enable);
    if (shift)       return MODE_SHIFT;
    else if (enable) return MODE_CAPTURE;
    else             return MODE_HOLD;
  endfunction

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl (
  input  logic clr_n,
  input  logic scan_en,
  output logic arst_n
);
  // Clear is gated off while shifting
  always_comb arst_n = clr_n | scan_en;
endmodule

// File: rtl/scan_cell.sv
module scan_cell
  import scan_chain_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic shift,
  input  logic enable,
  input  logic func_d,
  input  logic ser_in,
  output logic q,
  output logic qb,
  output logic ser_out
);
  cell_mode_t mode;
  logic       next_q;

  always_comb begin
    mode = pick_mode(shift, enable);
    unique case (mode)
      MODE_SHIFT:   next_q = ser_in;
      MODE_CAPTURE: next_q = func_d;
      default:      next_q = q;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= 1'b0;
    else         q <= next_q;
  end

  assign qb      = ~q;
  assign ser_out = q;
endmodule

// File: rtl/scan_reg_chain.sv
module scan_reg_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             scan_en,
  input  logic             scan_in,
  input  logic [WIDTH-1:0] cap_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] qb,
  output logic             scan_out
);
  localparam int LAST = WIDTH - 1;

  logic             arst_n;
  logic [WIDTH-1:0] link;

  scan_ctrl u_ctrl (
    .clr_n   (clr_n),
    .scan_en (scan_en),
    .arst_n  (arst_n)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic ser_src;
    if (i == 0) begin : g_head
      assign ser_src = scan_in;
    end else begin : g_body
      assign ser_src = link[i-1];
    end
    scan_cell u_cell (
      .clk     (clk),
      .arst_n  (arst_n),
      .shift   (scan_en),
      .enable  (cap_en[i]),
      .func_d  (d[i]),
      .ser_in  (ser_src),
      .q       (q[i]),
      .qb      (qb[i]),
      .ser_out (link[i])
    );
  end

  assign scan_out = link[LAST];
endmodule

// File: rtl/scan_reg_chain_chk.sv
module scan_reg_chain_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic             scan_en,
  input logic             scan_in,
  input logic [WIDTH-1:0] cap_en,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] qb,
  input logic             scan_out
);
  // R1
  capture_load_chk: assert property (@(posedge clk) disable iff (!clr_n && !scan_en)
    (!scan_en && clr_n) |=> ((q ^ $past(d)) & $past(cap_en)) == '0);
  // R2
  hold_bits_chk: assert property (@(posedge clk) disable iff (!clr_n && !scan_en)
    (!scan_en && clr_n) |=> ((q ^ $past(q)) & ~$past(cap_en)) == '0);
  // R3
  shift_head_chk: assert property (@(posedge clk) disable iff (!clr_n && !scan_en)
    scan_en |=> q[0] == $past(scan_in));
  // R3
  shift_body_chk: assert property (@(posedge clk) disable iff (!clr_n && !scan_en)
    scan_en |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));
  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (scan_en)
    !clr_n |-> q == '0);
  // R6
  compl_pair_chk: assert property (@(posedge clk) disable iff (!clr_n && !scan_en)
    ((q & qb) == '0) && ((q | qb) == '1));
  // R7
  serial_tail_chk: assert property (@(posedge clk) disable iff (!clr_n && !scan_en)
    scan_out == q[WIDTH-1]);
endmodule

bind scan_reg_chain scan_reg_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clr_n(clr_n), .scan_en(scan_en), .scan_in(scan_in),
  .cap_en(cap_en), .d(d), .q(q), .qb(qb), .scan_out(scan_out)
);

// File: tb/scan_reg_chain_test.sv
module scan_reg_chain_test;
  localparam int W = 8;
  localparam int NV = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         scan_en = 1'b0;
  logic         scan_in = 1'b0;
  logic [W-1:0] cap_en = '0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q, qb;
  logic         scan_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scan_reg_chain #(.WIDTH(W)) uut (
    .clk(clk), .clr_n(clr_n), .scan_en(scan_en), .scan_in(scan_in),
    .cap_en(cap_en), .d(d), .q(q), .qb(qb), .scan_out(scan_out)
  );

  // {scan_en, clr_n, scan_in, cap_en, d, expected q}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 8'hFF, 8'hA5, 8'hA5},  // R1 capture all
    {1'b0, 1'b1, 1'b0, 8'h0F, 8'h00, 8'hA0},  // R1/R2 partial
    {1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 8'hA0},  // R2 hold all
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'h41},  // R3 shift 1
    {1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF, 8'h82},  // R3 shift 0, d ignored
    {1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h05},  // R5 clear ignored
    {1'b0, 1'b1, 1'b0, 8'hF0, 8'h3C, 8'h35},  // R1/R2
    {1'b0, 1'b1, 1'b0, 8'h81, 8'hFF, 8'hB5}   // R1/R2
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    logic [W-1:0] pat;
    repeat (2) tick();
    check("R4 reset q", q, '0);
    check("R6 reset qb", qb, '1);
    check("R7 reset so", {7'b0, scan_out}, 8'h00);
    clr_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      {scan_en, clr_n, scan_in, cap_en, d} = VEC[k][26:8];
      tick();
      check($sformatf("R1/R2/R3/R5 vector %0d q", k), q, VEC[k][7:0]);
      check("R6 vector qb", qb, ~VEC[k][7:0]);
      check("R7 vector so", {7'b0, scan_out}, {7'b0, VEC[k][7]});
    end

    // R4: clear between edges, no clock
    scan_en = 1'b0; clr_n = 1'b1;
    #1 clr_n = 1'b0;
    #1 check("R4 async clear", q, '0);
    tick();
    check("R4 clear held", q, '0);

    // R9: raise scan_en during clear
    scan_en = 1'b1; scan_in = 1'b1;
    tick();
    check("R9 clear released by shift", q, 8'h01);
    clr_n = 1'b1;

    // R8: load, capture, unload
    pat = 8'hC6;
    for (int k = W - 1; k >= 0; k--) begin
      scan_in = pat[k];
      tick();
    end
    check("R8 loaded order", q, 8'hC6);
    scan_en = 1'b0; cap_en = '1; d = 8'h3B;
    tick();
    check("R8 capture", q, 8'h3B);
    scan_en = 1'b1; scan_in = 1'b0; d = 8'h00;
    got = '0;
    for (int k = W - 1; k >= 0; k--) begin
      got[k] = scan_out;
      tick();
    end
    check("R8 unloaded order", got, 8'h3B);
    check("R3 chain empty after unload", q, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule